// File: doc/BRIEF.md
# Trade Message Field Extractor

This block sits behind a byte-wide message stream with valid/ready flow control. The stream marks where each message starts and where it ends. The block counts the position of every accepted byte within its message. It recognises trade messages by the type byte at position 0 and pulls out four fields into registers: the buy/sell indicator, the share quantity, the eight-character instrument symbol and the price.

The block emits a trade event as early as it can. The event appears on the same clock cycle that the last price byte is accepted, so a downstream consumer can act before the rest of the message has arrived. The block then accepts the trailing bytes and discards them. Messages of any other type pass through the counter without producing an event.

The event output uses valid/ready flow control and has a single holding register. When that register is occupied and another price is about to complete, the input stalls on the final price byte. No event is lost or produced twice, and byte alignment within the message is preserved.

Top module: `trade_extractor`

## Requirements
- R1: After reset, `ev_valid` is 0 and `in_ready` is 1.
- R2: An event is produced only for a message whose byte at position 0 equals 0x50. A message with any other type byte produces no event.
- R3: Field positions are as follows, with multi-byte fields most-significant byte first:
  - `ev_side` is the byte at position 19.
  - `ev_shares` is positions 20..23.
  - `ev_stock` is positions 24..31.
  - `ev_price` is positions 32..35.
- R4: With the holding register empty, `ev_valid` is 1 in the same cycle that the position-35 byte of a trade message is accepted, and it carries the complete price.
- R5: Bytes after position 35 are accepted without stalling and create no further event, including in messages far longer than 44 bytes.
- R6: A message whose end marker comes before position 35 produces no event. The byte after an end marker is treated as position 0.
- R7: A start marker on an accepted byte makes that byte position 0, even if the previous message never ended.
- R8: While the holding register is full and the next byte would be position 35 of a trade message, `in_ready` is 0 until the held event is taken.
- R9: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid` and all event fields keep their values.
- R10: Each trade message yields exactly one event, and events leave in the order their messages arrived, including under periodic output stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Message payload byte |
| in_sop | input | 1 | Byte is first of a message |
| in_eop | input | 1 | Byte is last of a message |
| ev_valid | output | 1 | Trade event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_side | output | 8 | Buy/sell indicator |
| ev_shares | output | 32 | Share quantity |
| ev_stock | output | 64 | Instrument symbol |
| ev_price | output | 32 | Price |

## Verification
The assertions assume that the input follows the usual valid/ready rule: a presented byte and its markers are held until accepted. They also assume that the consumer only looks at the event fields while `ev_valid` is 1. The bench changes all inputs shortly after a rising edge and holds each byte until the design takes it. Output stalls come either from fixed `ev_ready` levels or from a repeating pattern that does not depend on the design's state. No stimulus marks a byte as both start and end.

// File: rtl/trx_pkg.sv
package trx_pkg;

    localparam int SIDE_BYTES   = 1;
    localparam int SHARES_BYTES = 4;
    localparam int STOCK_BYTES  = 8;
    localparam int PRICE_BYTES  = 4;

    localparam int SIDE_W   = 8 * SIDE_BYTES;
    localparam int SHARES_W = 8 * SHARES_BYTES;
    localparam int STOCK_W  = 8 * STOCK_BYTES;
    localparam int PRICE_W  = 8 * PRICE_BYTES;

    typedef struct packed {
        logic [SIDE_W-1:0]   side;
        logic [SHARES_W-1:0] shares;
        logic [STOCK_W-1:0]  stock;
        logic [PRICE_W-1:0]  price;
    } trade_ev_t;

endpackage

// File: rtl/trx_offset_trk.sv
module trx_offset_trk #(
    parameter int         PRICE_END = 35,
    parameter logic [7:0] TYPE_CODE = 8'h50,
    parameter int         OFF_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sop,
    input  logic             eop,
    input  logic [7:0]       data,
    output logic [OFF_W-1:0] cur_off,
    output logic             fire,
    output logic             stall_pending
);
    localparam logic [OFF_W-1:0] END_O = OFF_W'(PRICE_END);
    localparam logic [OFF_W-1:0] SAT_O = OFF_W'(PRICE_END + 1);

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic             trade;
    } pos_t;

    pos_t st_q, st_d;
    logic cur_trade;

    always_comb begin
        cur_off       = sop ? '0 : st_q.off;
        cur_trade     = (cur_off == '0) ? (data == TYPE_CODE) : st_q.trade;
        fire          = accept && cur_trade && (cur_off == END_O);
        stall_pending = st_q.trade && (st_q.off == END_O);
        st_d          = st_q;
        if (accept) begin
            if (eop) begin
                st_d.off   = '0;
                st_d.trade = 1'b0;
            end else begin
                st_d.off   = (cur_off == SAT_O) ? SAT_O : cur_off + 1'b1;
                st_d.trade = cur_trade;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/trx_field_cap.sv
module trx_field_cap
    import trx_pkg::*;
#(
    parameter int OFF_W      = 6,
    parameter int SIDE_OFF   = 19,
    parameter int SHARES_OFF = 20,
    parameter int STOCK_OFF  = 24,
    parameter int PRICE_OFF  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [OFF_W-1:0] cur_off,
    input  logic [7:0]       data,
    output trade_ev_t        ev_live
);
    localparam logic [OFF_W-1:0] SIDE_O = OFF_W'(SIDE_OFF);
    localparam logic [OFF_W-1:0] SH_LO  = OFF_W'(SHARES_OFF);
    localparam logic [OFF_W-1:0] SH_HI  = OFF_W'(SHARES_OFF + SHARES_BYTES - 1);
    localparam logic [OFF_W-1:0] ST_LO  = OFF_W'(STOCK_OFF);
    localparam logic [OFF_W-1:0] ST_HI  = OFF_W'(STOCK_OFF + STOCK_BYTES - 1);
    localparam logic [OFF_W-1:0] PR_LO  = OFF_W'(PRICE_OFF);
    localparam logic [OFF_W-1:0] PR_HI  = OFF_W'(PRICE_OFF + PRICE_BYTES - 2);

    trade_ev_t cap_q, cap_d;
    logic      in_sh, in_st, in_pr;

    always_comb begin
        in_sh = (cur_off >= SH_LO) && (cur_off <= SH_HI);
        in_st = (cur_off >= ST_LO) && (cur_off <= ST_HI);
        in_pr = (cur_off >= PR_LO) && (cur_off <= PR_HI);
        cap_d = cap_q;
        if (accept) begin
            if (cur_off == SIDE_O) cap_d.side   = data;
            if (in_sh)             cap_d.shares = {cap_q.shares[SHARES_W-9:0], data};
            if (in_st)             cap_d.stock  = {cap_q.stock[STOCK_W-9:0], data};
            if (in_pr)             cap_d.price  = {cap_q.price[PRICE_W-9:0], data};
        end
        ev_live       = cap_q;
        ev_live.price = {cap_q.price[PRICE_W-9:0], data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

endmodule

// File: rtl/trx_event_slot.sv
module trx_event_slot
    import trx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  trade_ev_t ev_in,
    input  logic      ev_ready,
    output logic      ev_valid,
    output trade_ev_t ev_out,
    output logic      full
);
    typedef struct packed {
        logic      full;
        trade_ev_t data;
    } slot_t;

    slot_t sl_q, sl_d;

    always_comb begin
        ev_valid = sl_q.full | fire;
        ev_out   = sl_q.full ? sl_q.data : ev_in;
        full     = sl_q.full;
        sl_d     = sl_q;
        if (sl_q.full) begin
            if (ev_ready) begin
                if (fire) sl_d.data = ev_in;
                else      sl_d.full = 1'b0;
            end
        end else if (fire && !ev_ready) begin
            sl_d.full = 1'b1;
            sl_d.data = ev_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

endmodule

// File: rtl/trade_extractor.sv
module trade_extractor
    import trx_pkg::*;
#(
    parameter logic [7:0] TYPE_CODE  = 8'h50,
    parameter int         SIDE_OFF   = 19,
    parameter int         SHARES_OFF = 20,
    parameter int         STOCK_OFF  = 24,
    parameter int         PRICE_OFF  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    input  logic                in_sop,
    input  logic                in_eop,
    output logic                ev_valid,
    input  logic                ev_ready,
    output logic [SIDE_W-1:0]   ev_side,
    output logic [SHARES_W-1:0] ev_shares,
    output logic [STOCK_W-1:0]  ev_stock,
    output logic [PRICE_W-1:0]  ev_price
);
    localparam int PRICE_END = PRICE_OFF + PRICE_BYTES - 1;
    localparam int OFF_W     = $clog2(PRICE_END + 2);

    logic             accept;
    logic             fire;
    logic             stall_pending;
    logic             slot_full;
    logic [OFF_W-1:0] cur_off;
    trade_ev_t        ev_live;
    trade_ev_t        ev_out;

    assign in_ready = !(slot_full && stall_pending);
    assign accept   = in_valid && in_ready;

    trx_offset_trk #(
        .PRICE_END (PRICE_END),
        .TYPE_CODE (TYPE_CODE),
        .OFF_W     (OFF_W)
    ) u_pos (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .sop           (in_sop),
        .eop           (in_eop),
        .data          (in_data),
        .cur_off       (cur_off),
        .fire          (fire),
        .stall_pending (stall_pending)
    );

    trx_field_cap #(
        .OFF_W      (OFF_W),
        .SIDE_OFF   (SIDE_OFF),
        .SHARES_OFF (SHARES_OFF),
        .STOCK_OFF  (STOCK_OFF),
        .PRICE_OFF  (PRICE_OFF)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cur_off (cur_off),
        .data    (in_data),
        .ev_live (ev_live)
    );

    trx_event_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .ev_in    (ev_live),
        .ev_ready (ev_ready),
        .ev_valid (ev_valid),
        .ev_out   (ev_out),
        .full     (slot_full)
    );

    assign ev_side   = ev_out.side;
    assign ev_shares = ev_out.shares;
    assign ev_stock  = ev_out.stock;
    assign ev_price  = ev_out.price;

endmodule

// File: rtl/trx_chk.sv
module trx_chk
    import trx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_ready,
    input logic                ev_valid,
    input logic                ev_ready,
    input logic [SIDE_W-1:0]   ev_side,
    input logic [SHARES_W-1:0] ev_shares,
    input logic [STOCK_W-1:0]  ev_stock,
    input logic [PRICE_W-1:0]  ev_price,
    input logic                fire,
    input logic                slot_full,
    input logic                stall_pending
);
    // R9: a stalled event stays present and unchanged
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable({ev_side, ev_shares, ev_stock, ev_price})));

    // R4: a completing price is visible at the output in the same cycle
    a_r4_fire_visible: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ev_valid);

    // R8: a full holding register blocks the final price byte
    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full && stall_pending) |-> !in_ready);

    // R8: no new event may appear while a held one is not being taken
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full && !ev_ready) |-> !fire);

    // R10: one dispatch per trade message, never two in a row
    a_r10_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

bind trade_extractor trx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .ev_valid      (ev_valid),
    .ev_ready      (ev_ready),
    .ev_side       (ev_side),
    .ev_shares     (ev_shares),
    .ev_stock      (ev_stock),
    .ev_price      (ev_price),
    .fire          (fire),
    .slot_full     (slot_full),
    .stall_pending (stall_pending)
);

// File: tb/trade_extractor_tb.sv
`timescale 1ns/1ps
module trade_extractor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        ev_valid;
    logic        ev_ready = 1'b1;
    logic [7:0]  ev_side;
    logic [31:0] ev_shares;
    logic [63:0] ev_stock;
    logic [31:0] ev_price;

    int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
    int cyc = 0, rdy_mode = 0, stall_waits = 0, ev_cnt = 0;
    logic [135:0] lg [0:31];
    logic         pend = 1'b0;
    logic [135:0] pend_val = '0;

    always #2 clk = ~clk;

    trade_extractor u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_side(ev_side),
        .ev_shares(ev_shares), .ev_stock(ev_stock), .ev_price(ev_price)
    );

    always begin
        @(posedge clk);
        #1;
        case (rdy_mode)
            0:       ev_ready = 1'b1;
            1:       ev_ready = 1'b0;
            default: ev_ready = (cyc % 3) != 0;
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual cycle=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
            $finish;
        end
    end

    // output monitor: records handshakes and checks R9 stability
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                mon_total++;
                if (!ev_valid || {ev_side, ev_shares, ev_stock, ev_price} != pend_val) begin
                    mon_bad++;
                    $display("FAIL R9: held event changed, actual=%h valid=%0d expected=%h",
                             {ev_side, ev_shares, ev_stock, ev_price}, ev_valid, pend_val);
                end
            end
            pend     = ev_valid && !ev_ready;
            pend_val = {ev_side, ev_shares, ev_stock, ev_price};
            if (ev_valid && ev_ready) begin
                if (ev_cnt < 32) lg[ev_cnt] = {ev_side, ev_shares, ev_stock, ev_price};
                ev_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int i, input logic [7:0] typ, input logic [7:0] sd,
                                         input logic [31:0] sh, input logic [63:0] st,
                                         input logic [31:0] pr);
        if (i == 0)                 return typ;
        if (i == 19)                return sd;
        if (i >= 20 && i <= 23)     return sh[8*(23-i) +: 8];
        if (i >= 24 && i <= 31)     return st[8*(31-i) +: 8];
        if (i >= 32 && i <= 35)     return pr[8*(35-i) +: 8];
        return 8'((i * 7 + 3) & 255);
    endfunction

    // drives a byte and returns at the falling edge before the edge that takes it
    task automatic push_byte(input logic [7:0] d, input logic s, input logic e);
        @(posedge clk);
        #1;
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            stall_waits++;
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_bytes(input logic [7:0] typ, input logic [7:0] sd, input logic [31:0] sh,
                              input logic [63:0] st, input logic [31:0] pr, input int len,
                              input int first, input int last, input bit early);
        for (int i = first; i <= last; i++) begin
            push_byte(mbyte(i, typ, sd, sh, st, pr), i == 0, i == len - 1);
            if (early && i == 35) begin
                check("R4 valid on last price byte", 136'(ev_valid), 136'(1));
                check("R4 price on last price byte", 136'(ev_price), 136'(pr));
            end
        end
    endtask

    task automatic send_msg(input logic [7:0] typ, input logic [7:0] sd, input logic [31:0] sh,
                            input logic [63:0] st, input logic [31:0] pr, input int len,
                            input bit early);
        send_bytes(typ, sd, sh, st, pr, len, 0, len - 1, early);
        idle();
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ev_valid after reset", 136'(ev_valid), 136'(0));
        check("R1 in_ready after reset", 136'(in_ready), 136'(1));
    endtask

    task automatic t_basic();
        int base = ev_cnt;
        rdy_mode = 0; stall_waits = 0;
        send_msg(8'h50, 8'h42, 32'h0000_1388, 64'h4142_4344_2020_2020, 32'h0012_D687, 44, 1'b1);
        settle();
        check("R10 one event for one trade", 136'(ev_cnt - base), 136'(1));
        check("R3 field positions", lg[base], {8'h42, 32'h0000_1388, 64'h4142_4344_2020_2020, 32'h0012_D687});
        check("R5 no stall on tail bytes", 136'(stall_waits), 136'(0));
    endtask

    task automatic t_other_type();
        int base = ev_cnt;
        stall_waits = 0;
        send_msg(8'h41, 8'h53, 32'h1, 64'h2, 32'h3, 44, 1'b0);
        send_msg(8'h51, 8'h53, 32'h1, 64'h2, 32'h3, 44, 1'b0);
        settle();
        check("R2 non-trade types give no event", 136'(ev_cnt - base), 136'(0));
        check("R2 output idle after non-trade", 136'(ev_valid), 136'(0));
        check("R5 non-trade consumed without stall", 136'(stall_waits), 136'(0));
    endtask

    task automatic t_short();
        int base = ev_cnt;
        send_msg(8'h50, 8'h53, 32'h11, 64'h22, 32'h33, 30, 1'b0);
        settle();
        check("R6 short trade gives no event", 136'(ev_cnt - base), 136'(0));
        // next message without a start marker: byte after end is position 0
        for (int i = 0; i < 44; i++)
            push_byte(mbyte(i, 8'h50, 8'h53, 32'hDEAD_0001, 64'h5859_5A20_2020_2020, 32'h0000_0064),
                      1'b0, i == 43);
        idle();
        settle();
        check("R6 realigned after end marker", 136'(ev_cnt - base), 136'(1));
        check("R6 realigned fields", lg[base],
              {8'h53, 32'hDEAD_0001, 64'h5859_5A20_2020_2020, 32'h0000_0064});
    endtask

    task automatic t_restart();
        int base = ev_cnt;
        send_bytes(8'h50, 8'h42, 32'h7, 64'h8, 32'h9, 44, 0, 27, 1'b0);
        send_msg(8'h50, 8'h42, 32'h0000_0777, 64'h4D4E_4F50_2020_2020, 32'h00AB_CDEF, 44, 1'b1);
        settle();
        check("R7 start marker restarts offset", 136'(ev_cnt - base), 136'(1));
        check("R7 fields after restart", lg[base],
              {8'h42, 32'h0000_0777, 64'h4D4E_4F50_2020_2020, 32'h00AB_CDEF});
    endtask

    task automatic t_stall();
        int base = ev_cnt;
        logic [135:0] ea = {8'h42, 32'h0000_00AA, 64'h4141_4141_4141_4141, 32'h0000_1111};
        logic [135:0] eb = {8'h53, 32'h0000_00BB, 64'h4242_4242_4242_4242, 32'h0000_2222};
        rdy_mode = 1;
        send_msg(8'h50, 8'h42, 32'hAA, 64'h4141_4141_4141_4141, 32'h1111, 44, 1'b0);
        settle();
        check("R9 held event present", 136'(ev_valid), 136'(1));
        send_bytes(8'h53 ^ 8'h03, 8'h53, 32'hBB, 64'h4242_4242_4242_4242, 32'h2222, 44, 0, 34, 1'b0);
        @(posedge clk);
        #1;
        in_data = mbyte(35, 8'h50, 8'h53, 32'hBB, 64'h4242_4242_4242_4242, 32'h2222);
        in_sop = 1'b0; in_eop = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R8 in_ready low on final price byte", 136'(in_ready), 136'(0));
            check("R9 held price kept", 136'(ev_price), 136'(32'h1111));
        end
        rdy_mode = 0;
        send_bytes(8'h50, 8'h53, 32'hBB, 64'h4242_4242_4242_4242, 32'h2222, 44, 35, 43, 1'b0);
        idle();
        settle();
        check("R10 two events after stall", 136'(ev_cnt - base), 136'(2));
        check("R10 first event order", lg[base], ea);
        check("R10 second event order", lg[base + 1], eb);
    endtask

    task automatic t_pattern();
        int base = ev_cnt;
        rdy_mode = 2;
        for (int k = 0; k < 3; k++) begin
            send_msg(8'h50, 8'h42 + 8'(k), 32'(100 + k), 64'(64'h5A00 + k), 32'(5000 + k), 44, 1'b0);
            if (k == 1) send_msg(8'h45, 8'h00, 32'h0, 64'h0, 32'h0, 40, 1'b0);
        end
        repeat (10) @(negedge clk);
        rdy_mode = 0;
        settle();
        check("R10 three events under periodic stall", 136'(ev_cnt - base), 136'(3));
        for (int k = 0; k < 3; k++)
            check("R10 order under periodic stall", lg[base + k],
                  {8'h42 + 8'(k), 32'(100 + k), 64'(64'h5A00 + k), 32'(5000 + k)});
    endtask

    task automatic t_long();
        int base = ev_cnt;
        rdy_mode = 0; stall_waits = 0;
        send_msg(8'h50, 8'h53, 32'h0001_0000, 64'h4C4F_4E47_2020_2020, 32'h7FFF_FFFF, 90, 1'b1);
        settle();
        check("R5 long message single event", 136'(ev_cnt - base), 136'(1));
        check("R5 long message no stall", 136'(stall_waits), 136'(0));
        check("R3 long message fields", lg[base],
              {8'h53, 32'h0001_0000, 64'h4C4F_4E47_2020_2020, 32'h7FFF_FFFF});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_other_type();
        t_short();
        t_restart();
        t_stall();
        t_pattern();
        t_long();
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

endmodule